// File: doc/BRIEF.md
# Stream-to-Memory Write Channel

This block takes one packet from a 32-bit stream input and stores it in a contiguous buffer in memory through a 64-bit AXI4 write master. It handles one packet per start and works from a single buffer. Software first programs a destination address and a byte limit through an AXI4-Lite register port. It then starts the channel. Afterwards it polls a status word and reads back the number of bytes that were actually taken in.

Two consecutive stream words make up one 64-bit memory beat, with the earlier word in the low half. A transfer ends at whichever comes first: the stream's end-of-packet flag or the byte limit. The stream input is held stalled whenever the channel is not armed. Every beat goes out as its own aligned single-beat write, so no write can cross a 4 KB page. Write responses are counted, and completion is reported only after the last one has arrived. A failed response raises a sticky error.

Top module: `s2mm_dma`

## Requirements
- R1: After reset the stream ready output is low, no AXI write channel is valid, and the status word (offset 0x04) reads 0.
- R2: The stream ready output stays low while the channel is not armed. This holds before the first start and again after each transfer has finished, until the control register (offset 0x00) is written with bit 0 set.
- R3: Each pair of stream words is written as one beat with the first word in bits 31:0, the second word in bits 63:32, and strobe 0xFF. Beat addresses start at the destination register (offset 0x08) with its low 3 bits forced to zero, and rise by 8 per beat. Every write uses length 0, size 3 and INCR burst type (01).
- R4: When the end-of-packet flag comes with an odd word, that word is written alone. It sits in bits 31:0, bits 63:32 are zero, and the upper four strobes are 0.
- R5: The limit register (offset 0x0C) bounds the transfer. The word that reaches the limit has its keep bits trimmed to the bytes that remain, ends the packet, and stream ready drops straight after it. When the end-of-packet flag falls on that same word, the transfer ends only once.
- R6: The count register (offset 0x10) reports the number of kept bytes accepted. Keep bits are taken as contiguous from bit 0, and each word's kept bytes become its strobes.
- R7: Status bit 0 (busy) stays set until every write response has returned. Status bit 1 (done) is set only when the transfer ends with no error and no halt.
- R8: A write response other than 00 sets status bit 2 (error). This bit stays set, done stays clear, and stream ready stays low until the next start, which clears the error.
- R9: Writing control bit 1 while a transfer runs stops the channel from taking stream data. Any unpaired half-beat is discarded, busy clears once the outstanding writes drain, and done stays clear.
- R10: A start with a limit of 0 finishes with done set, a count of 0, and no memory write.
- R11: The destination and limit registers read back the values written to them. The destination reads back with its low 3 bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | 5 | Lite write address |
| s_awvalid | input | 1 | Lite write address valid |
| s_awready | output | 1 | Lite write address ready |
| s_wdata | input | 32 | Lite write data |
| s_wvalid | input | 1 | Lite write data valid |
| s_wready | output | 1 | Lite write data ready |
| s_bresp | output | 2 | Lite write response (always OKAY) |
| s_bvalid | output | 1 | Lite write response valid |
| s_bready | input | 1 | Lite write response ready |
| s_araddr | input | 5 | Lite read address |
| s_arvalid | input | 1 | Lite read address valid |
| s_arready | output | 1 | Lite read address ready |
| s_rdata | output | 32 | Lite read data |
| s_rresp | output | 2 | Lite read response (always OKAY) |
| s_rvalid | output | 1 | Lite read data valid |
| s_rready | input | 1 | Lite read data ready |
| st_data | input | 32 | Stream word |
| st_keep | input | 4 | Stream byte keep |
| st_last | input | 1 | Stream end of packet |
| st_valid | input | 1 | Stream valid |
| st_ready | output | 1 | Stream ready |
| m_awaddr | output | 32 | Memory write address |
| m_awlen | output | 8 | Burst length (0) |
| m_awsize | output | 3 | Beat size (3 = 8 bytes) |
| m_awburst | output | 2 | Burst type (INCR) |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 64 | Write data |
| m_wstrb | output | 8 | Write byte strobes |
| m_wlast | output | 1 | Last beat (always 1) |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |

## Verification
The end-of-packet flag and the byte limit can end a transfer on the same stream word. The bench provokes this by sending two words with a limit of 8 and the flag on the second word. It then expects exactly one full-strobe beat, a count of 8 and a single clean completion. A limit that cuts a word in the middle is judged by the trimmed strobes and by stream ready dropping at the very next sample. The memory model stalls its ready signals in a pseudo-random pattern and delays its responses, so a response can arrive in the same cycle that a new beat is handed over.

// File: rtl/s2mm_pkg.sv
package s2mm_pkg;
    localparam int REG_AW = 5;
    localparam int BEAT_BYTES = 8;

    typedef struct packed {
        logic [63:0] data;
        logic [7:0]  strb;
    } beat_t;

    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_STAT  = 3'd1,
        SEL_DEST  = 3'd2,
        SEL_LIMIT = 3'd3,
        SEL_COUNT = 3'd4
    } reg_sel_e;

    // Trim contiguous keep bits to the bytes still allowed (room is 0..4).
    function automatic logic [3:0] clip_keep(input logic [3:0] keep, input logic [2:0] room);
        logic [3:0] m;
        case (room)
            3'd0:    m = 4'h0;
            3'd1:    m = 4'h1;
            3'd2:    m = 4'h3;
            3'd3:    m = 4'h7;
            default: m = 4'hF;
        endcase
        return keep & m;
    endfunction

    function automatic logic [2:0] ones4(input logic [3:0] k);
        return {2'b0, k[0]} + {2'b0, k[1]} + {2'b0, k[2]} + {2'b0, k[3]};
    endfunction
endpackage

// File: rtl/s2mm_packer.sv
module s2mm_packer
    import s2mm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        in_fire,
    input  logic [31:0] in_data,
    input  logic [3:0]  in_keep,
    input  logic        in_last,
    input  logic        take,
    output beat_t       beat,
    output logic        beat_v,
    output logic        ready,
    output logic        pending
);
    logic        half_v;
    logic [31:0] half_d;
    logic [3:0]  half_k;

    assign ready   = !beat_v;
    assign pending = half_v || beat_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_v <= 1'b0;
            half_d <= '0;
            half_k <= '0;
            beat   <= '0;
            beat_v <= 1'b0;
        end else begin
            if (take) beat_v <= 1'b0;
            if (in_fire) begin
                if (half_v) begin
                    beat   <= '{data: {in_data, half_d}, strb: {in_keep, half_k}};
                    beat_v <= 1'b1;
                    half_v <= 1'b0;
                end else if (in_last) begin
                    beat   <= '{data: {32'h0, in_data}, strb: {4'h0, in_keep}};
                    beat_v <= 1'b1;
                end else begin
                    half_d <= in_data;
                    half_k <= in_keep;
                    half_v <= 1'b1;
                end
            end
            if (flush) half_v <= 1'b0;
        end
    end

    // R3
    beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        beat_v && !take |=> beat_v && $stable(beat));
endmodule

// File: rtl/s2mm_writer.sv
module s2mm_writer
    import s2mm_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int OUTST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  beat_t             beat,
    input  logic              beat_v,
    output logic              take,
    output logic              idle,
    output logic              err,
    output logic [ADDR_W-1:0] m_awaddr,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [63:0]       m_wdata,
    output logic [7:0]        m_wstrb,
    output logic              m_wvalid,
    input  logic              m_wready,
    input  logic [1:0]        m_bresp,
    input  logic              m_bvalid,
    output logic              m_bready
);
    logic               iss, awv, wv;
    logic [ADDR_W-1:0]  addr;
    logic [OUTST_W-1:0] outst;
    logic               bfire;

    assign bfire     = m_bvalid && m_bready;
    assign take      = iss && (!awv || m_awready) && (!wv || m_wready);
    assign idle      = !iss && (outst == '0);
    assign err       = bfire && (m_bresp != 2'b00);
    assign m_bready  = 1'b1;
    assign m_awaddr  = addr;
    assign m_awvalid = awv;
    assign m_wvalid  = wv;
    assign m_wdata   = beat.data;
    assign m_wstrb   = beat.strb;

    always_ff @(posedge clk) begin
        if (rst) begin
            iss   <= 1'b0;
            awv   <= 1'b0;
            wv    <= 1'b0;
            addr  <= '0;
            outst <= '0;
        end else begin
            if (load) addr <= base;
            if (!iss && beat_v && !(&outst)) begin
                iss <= 1'b1;
                awv <= 1'b1;
                wv  <= 1'b1;
            end else begin
                if (awv && m_awready) awv <= 1'b0;
                if (wv && m_wready)   wv  <= 1'b0;
                if (take) begin
                    iss  <= 1'b0;
                    addr <= addr + ADDR_W'(BEAT_BYTES);
                end
            end
            outst <= outst + OUTST_W'(take) - OUTST_W'(bfire);
        end
    end

    // R3
    aw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));
    // R3
    aw_align_chk: assert property (@(posedge clk) disable iff (rst)
        m_awvalid |-> m_awaddr[2:0] == 3'b000);
    // R7
    b_owed_chk: assert property (@(posedge clk) disable iff (rst)
        m_bvalid |-> outst != '0);
endmodule

// File: rtl/s2mm_dma.sv
module s2mm_dma
    import s2mm_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 26,
    parameter int OUTST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [31:0]       s_wdata,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [REG_AW-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    input  logic [31:0]       st_data,
    input  logic [3:0]        st_keep,
    input  logic              st_last,
    input  logic              st_valid,
    output logic              st_ready,
    output logic [ADDR_W-1:0] m_awaddr,
    output logic [7:0]        m_awlen,
    output logic [2:0]        m_awsize,
    output logic [1:0]        m_awburst,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [63:0]       m_wdata,
    output logic [7:0]        m_wstrb,
    output logic              m_wlast,
    output logic              m_wvalid,
    input  logic              m_wready,
    input  logic [1:0]        m_bresp,
    input  logic              m_bvalid,
    output logic              m_bready
);
    logic              busy, fin, done_q, err_q, halted;
    logic [ADDR_W-1:0] dest;
    logic [LEN_W-1:0]  lim, cnt, rem;
    logic [2:0]        room, nb;
    logic [3:0]        keep_eff;
    logic              wr_fire, go, halt, fire, at_lim, complete;
    logic              pk_ready, pk_pending, beat_v, take, wr_idle, wr_err;
    beat_t             beat;
    reg_sel_e          wsel, rsel;
    logic              unused_ok;

    assign unused_ok = &{1'b0, s_awaddr[1:0], s_araddr[1:0]};
    assign wsel      = reg_sel_e'(s_awaddr[REG_AW-1:2]);
    assign rsel      = reg_sel_e'(s_araddr[REG_AW-1:2]);
    assign wr_fire   = s_awvalid && s_wvalid && !s_bvalid;
    assign s_awready = s_wvalid && !s_bvalid;
    assign s_wready  = s_awvalid && !s_bvalid;
    assign s_bresp   = 2'b00;
    assign s_rresp   = 2'b00;
    assign s_arready = !s_rvalid;

    assign go   = wr_fire && wsel == SEL_CTRL && s_wdata[0] && !busy;
    assign halt = wr_fire && wsel == SEL_CTRL && s_wdata[1] && busy && !fin;

    assign rem      = lim - cnt;
    assign room     = (|rem[LEN_W-1:2]) ? 3'd4 : {1'b0, rem[1:0]};
    assign keep_eff = clip_keep(st_keep, room);
    assign nb       = ones4(keep_eff);
    assign at_lim   = rem == {{(LEN_W-3){1'b0}}, nb};
    assign st_ready = busy && !fin && pk_ready;
    assign fire     = st_valid && st_ready;
    assign complete = busy && fin && !pk_pending && wr_idle && !wr_err;

    assign m_awlen   = 8'd0;
    assign m_awsize  = 3'd3;
    assign m_awburst = 2'b01;
    assign m_wlast   = 1'b1;

    s2mm_packer u_pack (
        .clk(clk), .rst(rst), .flush(halt || wr_err), .in_fire(fire),
        .in_data(st_data), .in_keep(keep_eff), .in_last(st_last || at_lim),
        .take(take), .beat(beat), .beat_v(beat_v), .ready(pk_ready),
        .pending(pk_pending)
    );

    s2mm_writer #(.ADDR_W(ADDR_W), .OUTST_W(OUTST_W)) u_wr (
        .clk(clk), .rst(rst), .load(go), .base(dest), .beat(beat),
        .beat_v(beat_v), .take(take), .idle(wr_idle), .err(wr_err),
        .m_awaddr(m_awaddr), .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid),
        .m_wready(m_wready), .m_bresp(m_bresp), .m_bvalid(m_bvalid),
        .m_bready(m_bready)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0; fin <= 1'b0; done_q <= 1'b0; err_q <= 1'b0; halted <= 1'b0;
            dest <= '0; lim <= '0; cnt <= '0;
            s_bvalid <= 1'b0; s_rvalid <= 1'b0; s_rdata <= '0;
        end else begin
            if (go) begin
                busy   <= 1'b1;
                fin    <= (lim == '0);
                cnt    <= '0;
                done_q <= 1'b0;
                err_q  <= 1'b0;
                halted <= 1'b0;
            end else begin
                if (fire) begin
                    cnt <= cnt + LEN_W'(nb);
                    if (st_last || at_lim) fin <= 1'b1;
                end
                if (halt) begin
                    fin    <= 1'b1;
                    halted <= 1'b1;
                end
                if (wr_err) begin
                    fin   <= 1'b1;
                    err_q <= 1'b1;
                end
                if (complete) begin
                    busy   <= 1'b0;
                    done_q <= !halted && !err_q;
                end
            end
            if (wr_fire && !busy && wsel == SEL_DEST)  dest <= ADDR_W'(s_wdata) & ~ADDR_W'(7);
            if (wr_fire && !busy && wsel == SEL_LIMIT) lim  <= s_wdata[LEN_W-1:0];
            if (wr_fire)       s_bvalid <= 1'b1;
            else if (s_bready) s_bvalid <= 1'b0;
            if (s_arvalid && !s_rvalid) begin
                s_rvalid <= 1'b1;
                case (rsel)
                    SEL_STAT:  s_rdata <= {29'd0, err_q, done_q, busy};
                    SEL_DEST:  s_rdata <= 32'(dest);
                    SEL_LIMIT: s_rdata <= 32'(lim);
                    SEL_COUNT: s_rdata <= 32'(cnt);
                    default:   s_rdata <= '0;
                endcase
            end else if (s_rready) begin
                s_rvalid <= 1'b0;
            end
        end
    end

    // R2
    idle_stall_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !st_ready);
    // R5
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> cnt <= lim);
    // R8
    done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(done_q && err_q));
endmodule

// File: tb/s2mm_dma_test.sv
module s2mm_dma_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [4:0]  s_awaddr = '0, s_araddr = '0;
    logic        s_awvalid = 0, s_wvalid = 0, s_arvalid = 0;
    logic [31:0] s_wdata = '0;
    logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0]  s_bresp, s_rresp;
    logic [31:0] s_rdata;
    logic [31:0] st_data = '0;
    logic [3:0]  st_keep = '0;
    logic        st_last = 0, st_valid = 0, st_ready;
    logic [31:0] m_awaddr;
    logic [7:0]  m_awlen;
    logic [2:0]  m_awsize;
    logic [1:0]  m_awburst;
    logic        m_awvalid, m_wlast, m_wvalid, m_bready;
    logic        m_awready = 0, m_wready = 0, m_bvalid = 0;
    logic [63:0] m_wdata;
    logic [7:0]  m_wstrb;
    logic [1:0]  m_bresp = '0;

    s2mm_dma uut (
        .clk(clk), .rst(rst),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(1'b1),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(1'b1),
        .st_data(st_data), .st_keep(st_keep), .st_last(st_last),
        .st_valid(st_valid), .st_ready(st_ready),
        .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize),
        .m_awburst(m_awburst), .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast),
        .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready)
    );

    int nchk = 0, nerr = 0;
    int naw = 0, nw = 0, nbi = 0, err_idx = -1;
    logic [31:0] aw_log [0:255];
    logic [63:0] wd_log [0:255];
    logic [7:0]  ws_log [0:255];
    logic [15:0] lfsr = 16'hACE1;

    // Memory-side model: random stalls, delayed responses, optional error.
    always @(posedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (rst) begin
            m_awready <= 0; m_wready <= 0; m_bvalid <= 0;
        end else begin
            if (m_awvalid && m_awready) begin
                aw_log[naw] = m_awaddr;
                if (m_awlen != 0 || m_awsize != 3'd3 || m_awburst != 2'b01) begin
                    nerr++;
                    $display("FAIL R3: burst fields %h/%h/%h expected 0/3/1", m_awlen, m_awsize, m_awburst);
                end
                naw++;
            end
            if (m_wvalid && m_wready) begin
                wd_log[nw] = m_wdata; ws_log[nw] = m_wstrb; nw++;
            end
            if (m_bvalid && m_bready) m_bvalid <= 0;
            if ((!m_bvalid || m_bready) && nbi < naw && nbi < nw && lfsr[3]) begin
                m_bvalid <= 1;
                m_bresp  <= (nbi == err_idx) ? 2'b10 : 2'b00;
                nbi++;
            end
            m_awready <= lfsr[0] | lfsr[5];
            m_wready  <= lfsr[1] | lfsr[7];
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic lite_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        s_awaddr = a; s_wdata = d; s_awvalid = 1; s_wvalid = 1; #1;
        while (!s_awready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        s_awvalid = 0; s_wvalid = 0;
    endtask

    task automatic lite_rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        s_araddr = a; s_arvalid = 1; #1;
        while (!s_arready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        s_arvalid = 0;
        d = s_rdata;
    endtask

    task automatic push(input logic [31:0] d, input logic [3:0] k, input logic l);
        @(negedge clk);
        st_data = d; st_keep = k; st_last = l; st_valid = 1; #1;
        while (!st_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        st_valid = 0; st_last = 0;
    endtask

    task automatic wait_idle(output logic [31:0] st);
        st = 32'h1;
        for (int i = 0; i < 2000; i++) begin
            lite_rd(5'h04, st);
            if (!st[0]) break;
        end
    endtask

    task automatic arm(input logic [31:0] dst, input logic [31:0] lim);
        lite_wr(5'h08, dst);
        lite_wr(5'h0C, lim);
        lite_wr(5'h00, 32'h1);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 ready", {63'd0, st_ready}, 64'd0);
        chk("R1 awvalid", {62'd0, m_awvalid, m_wvalid}, 64'd0);
        lite_rd(5'h04, v);
        chk("R1 status", {32'd0, v}, 64'd0);
    endtask

    task automatic t_idle_stall;
        int seen = 0;
        st_valid = 1; st_data = 32'hDEAD; st_keep = 4'hF;
        for (int i = 0; i < 6; i++) begin @(negedge clk); #1; if (st_ready) seen++; end
        st_valid = 0;
        chk("R2 stall before start", 64'(seen), 64'd0);
        chk("R2 no writes", 64'(naw), 64'd0);
    endtask

    task automatic t_even;
        logic [31:0] v; int b0 = nw;
        arm(32'h1000_0005, 32'd1000);
        lite_rd(5'h08, v); chk("R11 dest readback", {32'd0, v}, 64'h1000_0000);
        lite_rd(5'h0C, v); chk("R11 limit readback", {32'd0, v}, 64'd1000);
        lite_rd(5'h04, v); chk("R7 busy while open", {32'd0, v}, 64'h1);
        push(32'hA0, 4'hF, 0); push(32'hA1, 4'hF, 0);
        push(32'hA2, 4'hF, 0); push(32'hA3, 4'hF, 1);
        wait_idle(v);
        chk("R7 done", {32'd0, v}, 64'h2);
        chk("R7 all responses back", 64'(nbi), 64'(naw));
        chk("R3 beat count", 64'(nw - b0), 64'd2);
        chk("R3 addr0", {32'd0, aw_log[b0]}, 64'h1000_0000);
        chk("R3 addr1", {32'd0, aw_log[b0+1]}, 64'h1000_0008);
        chk("R3 data0", wd_log[b0], 64'h0000_00A1_0000_00A0);
        chk("R3 data1", wd_log[b0+1], 64'h0000_00A3_0000_00A2);
        chk("R3 strb", {48'd0, ws_log[b0], ws_log[b0+1]}, 64'hFFFF);
        lite_rd(5'h10, v); chk("R6 count", {32'd0, v}, 64'd16);
        @(negedge clk); #1; chk("R2 stall after done", {63'd0, st_ready}, 64'd0);
    endtask

    task automatic t_odd;
        logic [31:0] v; int b0 = nw;
        arm(32'h2000_0000, 32'd1000);
        push(32'h11, 4'hF, 0); push(32'h22, 4'hF, 0); push(32'h3333, 4'h3, 1);
        wait_idle(v);
        chk("R4 beats", 64'(nw - b0), 64'd2);
        chk("R4 odd data", wd_log[b0+1], 64'h0000_0000_0000_3333);
        chk("R4 odd strb", {56'd0, ws_log[b0+1]}, 64'h03);
        chk("R4 addr", {32'd0, aw_log[b0+1]}, 64'h2000_0008);
        lite_rd(5'h10, v); chk("R6 partial keep count", {32'd0, v}, 64'd10);
    endtask

    task automatic t_limit;
        logic [31:0] v; int b0 = nw;
        arm(32'h3000_0000, 32'd10);
        push(32'hB0, 4'hF, 0); push(32'hB1, 4'hF, 0); push(32'hB2, 4'hF, 0);
        @(negedge clk); #1; chk("R5 ready drops at limit", {63'd0, st_ready}, 64'd0);
        wait_idle(v);
        chk("R5 done", {32'd0, v}, 64'h2);
        chk("R5 beats", 64'(nw - b0), 64'd2);
        chk("R5 trimmed strb", {56'd0, ws_log[b0+1]}, 64'h03);
        lite_rd(5'h10, v); chk("R5 count", {32'd0, v}, 64'd10);
    endtask

    task automatic t_both_end;
        logic [31:0] v; int b0 = nw;
        arm(32'h3100_0000, 32'd8);
        push(32'hC0, 4'hF, 0); push(32'hC1, 4'hF, 1);
        wait_idle(v);
        chk("R5 coincide done", {32'd0, v}, 64'h2);
        chk("R5 coincide beats", 64'(nw - b0), 64'd1);
        chk("R5 coincide data", wd_log[b0], 64'h0000_00C1_0000_00C0);
        lite_rd(5'h10, v); chk("R5 coincide count", {32'd0, v}, 64'd8);
    endtask

    task automatic t_error;
        logic [31:0] v;
        err_idx = nw;
        arm(32'h4000_0000, 32'd100);
        push(32'hE0, 4'hF, 0); push(32'hE1, 4'hF, 1);
        wait_idle(v);
        chk("R8 error status", {32'd0, v}, 64'h4);
        @(negedge clk); #1; chk("R8 ready low", {63'd0, st_ready}, 64'd0);
        lite_rd(5'h04, v); chk("R8 sticky", {32'd0, v}, 64'h4);
        err_idx = -1;
        lite_wr(5'h00, 32'h1);
        lite_rd(5'h04, v); chk("R8 restart clears", {32'd0, v}, 64'h1);
        push(32'hE2, 4'hF, 0); push(32'hE3, 4'hF, 1);
        wait_idle(v);
        chk("R8 clean after restart", {32'd0, v}, 64'h2);
    endtask

    task automatic t_halt;
        logic [31:0] v; int b0;
        arm(32'h5000_0000, 32'd100);
        push(32'hF0, 4'hF, 0);
        b0 = nw;
        lite_wr(5'h00, 32'h2);
        wait_idle(v);
        chk("R9 halted status", {32'd0, v}, 64'h0);
        chk("R9 half dropped", 64'(nw - b0), 64'd0);
        lite_rd(5'h10, v); chk("R9 count", {32'd0, v}, 64'd4);
        @(negedge clk); #1; chk("R9 ready low", {63'd0, st_ready}, 64'd0);
    endtask

    task automatic t_zero;
        logic [31:0] v; int b0 = nw;
        arm(32'h6000_0000, 32'd0);
        wait_idle(v);
        chk("R10 done", {32'd0, v}, 64'h2);
        lite_rd(5'h10, v); chk("R10 count", {32'd0, v}, 64'd0);
        repeat (20) @(negedge clk);
        chk("R10 no writes", 64'(nw - b0), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_idle_stall();
        t_even();
        t_odd();
        t_limit();
        t_both_end();
        t_error();
        t_halt();
        t_zero();
        repeat (5) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule